// File: doc/BRIEF.md
# Interrupt Enable and Exception Return Controller

This block executes four privileged control operations for a processor core: disable interrupts, enable interrupts, return from exception, and return from debug. The pipeline presents a one-hot request together with the current Status word, the three saved return addresses and the debug-mode flag. One clock later, the block presents its results as registered outputs. These are the rewritten Status word with a write strobe, the Status value seen before an interrupt-enable change, and the return target with a redirect strobe. A further strobe invalidates any load-linked reservation, so that a pending store-conditional fails. Two more strobes tell the core that execution must restart from the new state and that it has left debug mode.

The exception return picks its target and the flag it clears from the error-level bit. When the error level is set, the saved error address is used and only the error-level bit is cleared. Otherwise the saved exception address is used and the exception-level bit is cleared. A debug return issued outside debug mode, or a request with more than one bit set, is refused with a reserved-instruction flag and has no other effect. Interrupt arbitration, privilege-mode tracking and pipeline flushing belong to the surrounding core.

Top module: `excret_unit`

## Requirements
- R1: Reset state. While rst_n is low, and after it is released until the first request, every output is zero.
- R2: Disable. A request with op_i bit 0 alone set has the following effect one clock later:
  - status_wr_o pulses.
  - status_o equals the sampled status_i with bit 0 (interrupt enable) cleared.
  - old_status_o equals the sampled status_i.
- R3: Enable. A request with op_i bit 1 alone set does the same as R2, except that bit 0 of status_o is set.
- R4: Exception return with error level. A request with op_i bit 2 alone set, while status_i bit 2 is 1, has the following effect one clock later:
  - pc_o equals err_epc_i.
  - status_o equals status_i with only bit 2 cleared.
  - status_wr_o pulses.
- R5: Exception return without error level. The same request, while status_i bit 2 is 0, gives pc_o equal to epc_i and status_o equal to status_i with only bit 1 (exception level) cleared.
- R6: Debug return. A request with op_i bit 3 alone set, while dbg_mode_i is 1, has the following effect one clock later:
  - pc_o equals dbg_epc_i.
  - dbg_exit_o pulses.
  - status_wr_o stays low.
- R7: ll_clr_o pulses exactly for accepted exception and debug returns, in the same cycle as their redirect.
- R8: redirect_o pulses for one cycle only after accepted returns. restart_o pulses after every accepted request of the four kinds.
- R9: A debug return with dbg_mode_i 0, or any op_i with two or more bits set, pulses rsvd_o only. No other strobe fires, and status_o, old_status_o and pc_o keep their values.
- R10: Status bits other than bits 0, 1 and 2 pass through every Status write unchanged.
- R11: A cycle with op_i zero leaves every strobe low and every held output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | One-hot request: bit0 disable, bit1 enable, bit2 exception return, bit3 debug return |
| status_i | input | SW | Current Status word |
| epc_i | input | AW | Saved exception return address |
| err_epc_i | input | AW | Saved error return address |
| dbg_epc_i | input | AW | Saved debug return address |
| dbg_mode_i | input | 1 | Core is in debug mode |
| status_o | output | SW | Updated Status word (held) |
| status_wr_o | output | 1 | Status write strobe |
| old_status_o | output | SW | Status before the last disable/enable (held) |
| pc_o | output | AW | Return target (held) |
| redirect_o | output | 1 | Fetch redirect strobe |
| ll_clr_o | output | 1 | Load-linked reservation clear strobe |
| dbg_exit_o | output | 1 | Debug mode exit strobe |
| restart_o | output | 1 | Restart from new state strobe |
| rsvd_o | output | 1 | Reserved-instruction strobe |

## Verification
Every result is registered exactly once. A wrong decode, a wrong target choice or a wrong bit update therefore appears at the ports on the first clock after the offending request. A wrong held value persists and shows up in the next comparison, even on idle cycles. Refused requests and idle cycles are checked by comparing the held outputs against the values from the previous accepted request, so a stray update cannot go unseen.

// File: rtl/excret_pkg.sv
package excret_pkg;
    localparam int OP_W     = 4;
    localparam int OPB_DI   = 0;
    localparam int OPB_EI   = 1;
    localparam int OPB_ERET = 2;
    localparam int OPB_DRET = 3;

    localparam int ST_IE  = 0;
    localparam int ST_EXL = 1;
    localparam int ST_ERL = 2;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_DI   = 3'd1,
        K_EI   = 3'd2,
        K_ERET = 3'd3,
        K_DRET = 3'd4,
        K_RSVD = 3'd5
    } kind_e;
endpackage

// File: rtl/excret_decode.sv
module excret_decode
    import excret_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic            dbg_mode_i,
    output kind_e           kind_o
);
    logic [2:0] nbits;

    always_comb begin
        nbits = 3'($countones(op_i));
        kind_o = K_NONE;
        if (nbits > 3'd1) begin
            kind_o = K_RSVD;
        end else if (op_i[OPB_DI]) begin
            kind_o = K_DI;
        end else if (op_i[OPB_EI]) begin
            kind_o = K_EI;
        end else if (op_i[OPB_ERET]) begin
            kind_o = K_ERET;
        end else if (op_i[OPB_DRET]) begin
            kind_o = dbg_mode_i ? K_DRET : K_RSVD;
        end
    end
endmodule

// File: rtl/excret_status_upd.sv
module excret_status_upd
    import excret_pkg::*;
#(
    parameter int SW = 32
) (
    input  kind_e         kind_i,
    input  logic [SW-1:0] status_i,
    output logic [SW-1:0] status_nxt_o,
    output logic          wr_o
);
    logic erl_set;
    assign erl_set = status_i[ST_ERL];
    assign wr_o = (kind_i == K_DI) || (kind_i == K_EI) || (kind_i == K_ERET);

    for (genvar b = 0; b < SW; b++) begin : g_bit
        if (b == ST_IE) begin : g_ie
            assign status_nxt_o[b] = (kind_i == K_EI) ? 1'b1 :
                                     (kind_i == K_DI) ? 1'b0 : status_i[b];
        end else if (b == ST_EXL) begin : g_exl
            assign status_nxt_o[b] = (kind_i == K_ERET && !erl_set) ? 1'b0 : status_i[b];
        end else if (b == ST_ERL) begin : g_erl
            assign status_nxt_o[b] = (kind_i == K_ERET && erl_set) ? 1'b0 : status_i[b];
        end else begin : g_pass
            assign status_nxt_o[b] = status_i[b];
        end
    end
endmodule

// File: rtl/excret_target_sel.sv
module excret_target_sel
    import excret_pkg::*;
#(
    parameter int AW = 32
) (
    input  kind_e         kind_i,
    input  logic          erl_i,
    input  logic [AW-1:0] epc_i,
    input  logic [AW-1:0] err_epc_i,
    input  logic [AW-1:0] dbg_epc_i,
    output logic [AW-1:0] target_o,
    output logic          take_o
);
    always_comb begin
        target_o = '0;
        take_o   = 1'b0;
        unique case (kind_i)
            K_ERET: begin
                take_o   = 1'b1;
                target_o = erl_i ? err_epc_i : epc_i;
            end
            K_DRET: begin
                take_o   = 1'b1;
                target_o = dbg_epc_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/excret_unit.sv
module excret_unit
    import excret_pkg::*;
#(
    parameter int SW = 32,
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic [SW-1:0]   status_i,
    input  logic [AW-1:0]   epc_i,
    input  logic [AW-1:0]   err_epc_i,
    input  logic [AW-1:0]   dbg_epc_i,
    input  logic            dbg_mode_i,
    output logic [SW-1:0]   status_o,
    output logic            status_wr_o,
    output logic [SW-1:0]   old_status_o,
    output logic [AW-1:0]   pc_o,
    output logic            redirect_o,
    output logic            ll_clr_o,
    output logic            dbg_exit_o,
    output logic            restart_o,
    output logic            rsvd_o
);
    typedef struct packed {
        logic [SW-1:0] status;
        logic [SW-1:0] old_status;
        logic [AW-1:0] pc;
        logic          status_wr;
        logic          redirect;
        logic          ll_clr;
        logic          dbg_exit;
        logic          restart;
        logic          rsvd;
    } state_t;

    state_t        st_d, st_q;
    kind_e         kind;
    logic [SW-1:0] status_nxt;
    logic          status_wr;
    logic [AW-1:0] target;
    logic          take;

    excret_decode u_dec (
        .op_i       (op_i),
        .dbg_mode_i (dbg_mode_i),
        .kind_o     (kind)
    );

    excret_status_upd #(.SW(SW)) u_st (
        .kind_i       (kind),
        .status_i     (status_i),
        .status_nxt_o (status_nxt),
        .wr_o         (status_wr)
    );

    excret_target_sel #(.AW(AW)) u_tgt (
        .kind_i    (kind),
        .erl_i     (status_i[ST_ERL]),
        .epc_i     (epc_i),
        .err_epc_i (err_epc_i),
        .dbg_epc_i (dbg_epc_i),
        .target_o  (target),
        .take_o    (take)
    );

    always_comb begin
        st_d           = st_q;
        st_d.status_wr = 1'b0;
        st_d.redirect  = 1'b0;
        st_d.ll_clr    = 1'b0;
        st_d.dbg_exit  = 1'b0;
        st_d.restart   = 1'b0;
        st_d.rsvd      = (kind == K_RSVD);
        if (status_wr) begin
            st_d.status    = status_nxt;
            st_d.status_wr = 1'b1;
        end
        if (kind == K_DI || kind == K_EI) begin
            st_d.old_status = status_i;
        end
        if (take) begin
            st_d.pc       = target;
            st_d.redirect = 1'b1;
            st_d.ll_clr   = 1'b1;
        end
        st_d.dbg_exit = (kind == K_DRET);
        st_d.restart  = (kind == K_DI) || (kind == K_EI) ||
                        (kind == K_ERET) || (kind == K_DRET);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o     = st_q.status;
    assign status_wr_o  = st_q.status_wr;
    assign old_status_o = st_q.old_status;
    assign pc_o         = st_q.pc;
    assign redirect_o   = st_q.redirect;
    assign ll_clr_o     = st_q.ll_clr;
    assign dbg_exit_o   = st_q.dbg_exit;
    assign restart_o    = st_q.restart;
    assign rsvd_o       = st_q.rsvd;

    // Checks: history flag so $past never reaches before reset release
    logic past_ok_q;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    p_di_ie_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(op_i) == 4'b0001 |-> status_wr_o && !status_o[ST_IE]
            && old_status_o == $past(status_i));

    p_ei_ie_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(op_i) == 4'b0010 |-> status_wr_o && status_o[ST_IE]);

    p_eret_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(op_i) == 4'b0100 && $past(status_i[ST_ERL])
            |-> pc_o == $past(err_epc_i) && !status_o[ST_ERL]);

    p_eret_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(op_i) == 4'b0100 && !$past(status_i[ST_ERL])
            |-> pc_o == $past(epc_i) && !status_o[ST_EXL]);

    p_ll_with_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ll_clr_o == redirect_o);

    p_redirect_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> restart_o && !status_wr_o == dbg_exit_o);

    p_rsvd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_o |-> !status_wr_o && !redirect_o && !restart_o && !dbg_exit_o
            && $stable(pc_o) && $stable(status_o));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(op_i) == 4'b0000 |-> !restart_o && !rsvd_o && $stable(pc_o));
endmodule

// File: tb/excret_unit_tb.sv
module excret_unit_tb;
    localparam int SW = 32;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op_i = '0;
    logic [SW-1:0] status_i = '0;
    logic [AW-1:0] epc_i = '0, err_epc_i = '0, dbg_epc_i = '0;
    logic          dbg_mode_i = 1'b0;
    logic [SW-1:0] status_o, old_status_o;
    logic [AW-1:0] pc_o;
    logic status_wr_o, redirect_o, ll_clr_o, dbg_exit_o, restart_o, rsvd_o;

    int total = 0;
    int bad = 0;

    // expected held state
    logic [SW-1:0] e_status = '0, e_old = '0;
    logic [AW-1:0] e_pc = '0;

    always #10 clk = ~clk;

    excret_unit #(.SW(SW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .status_i(status_i),
        .epc_i(epc_i), .err_epc_i(err_epc_i), .dbg_epc_i(dbg_epc_i),
        .dbg_mode_i(dbg_mode_i), .status_o(status_o), .status_wr_o(status_wr_o),
        .old_status_o(old_status_o), .pc_o(pc_o), .redirect_o(redirect_o),
        .ll_clr_o(ll_clr_o), .dbg_exit_o(dbg_exit_o), .restart_o(restart_o),
        .rsvd_o(rsvd_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // strobes packed: {wr, redirect, ll, dbg_exit, restart, rsvd}
    task automatic run_op(input logic [3:0] op, input logic [SW-1:0] st,
                          input logic [AW-1:0] e, input logic [AW-1:0] ee,
                          input logic [AW-1:0] de, input logic dm, input string tag);
        logic [5:0] e_str;
        int n;
        n = $countones(op);
        e_str = '0;
        @(negedge clk);
        op_i = op; status_i = st; epc_i = e; err_epc_i = ee; dbg_epc_i = de; dbg_mode_i = dm;
        if (n > 1 || (op == 4'b1000 && !dm)) begin
            e_str = 6'b000001;                          // R9
        end else if (op == 4'b0001) begin
            e_str = 6'b100010; e_old = st; e_status = st & ~32'h1;          // R2
        end else if (op == 4'b0010) begin
            e_str = 6'b100010; e_old = st; e_status = st | 32'h1;           // R3
        end else if (op == 4'b0100) begin
            e_str = 6'b111010;
            if (st[2]) begin e_pc = ee; e_status = st & ~32'h4; end         // R4
            else       begin e_pc = e;  e_status = st & ~32'h2; end         // R5
        end else if (op == 4'b1000) begin
            e_str = 6'b011110; e_pc = de;                                   // R6
        end
        @(posedge clk); #1;
        chk({tag, " strobes R7 R8"},
            {58'd0, status_wr_o, redirect_o, ll_clr_o, dbg_exit_o, restart_o, rsvd_o},
            {58'd0, e_str});
        chk({tag, " status R10"}, {32'd0, status_o}, {32'd0, e_status});
        chk({tag, " old_status"}, {32'd0, old_status_o}, {32'd0, e_old});
        chk({tag, " pc"}, {32'd0, pc_o}, {32'd0, e_pc});
        op_i = '0;
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'h5eed_0042);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset strobes", {58'd0, status_wr_o, redirect_o, ll_clr_o, dbg_exit_o, restart_o, rsvd_o}, 64'd0);
        chk("R1 reset held", {status_o, pc_o}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after release", {old_status_o, pc_o}, 64'd0);

        // directed corners
        run_op(4'b0001, 32'hFFFF_FFFF, 1, 2, 3, 0, "R2 di all-ones");
        run_op(4'b0010, 32'h8000_0000, 1, 2, 3, 0, "R3 ei");
        run_op(4'b0100, 32'hA5A5_A5A7, 32'h100, 32'h200, 32'h300, 0, "R4 eret erl");
        run_op(4'b0100, 32'h0000_0003, 32'h104, 32'h204, 32'h304, 0, "R5 eret exl");
        run_op(4'b1000, 32'h1234_5678, 32'h108, 32'h208, 32'h308, 1, "R6 deret");
        run_op(4'b1000, 32'h0, 32'h10C, 32'h20C, 32'hDEAD, 0, "R9 deret no dbg");
        run_op(4'b0101, 32'h7, 32'h110, 32'h210, 32'h310, 1, "R9 multi");
        run_op(4'b0000, 32'hFFFF, 32'h114, 32'h214, 32'h314, 1, "R11 idle");
        run_op(4'b0100, 32'h0000_0006, 32'h118, 32'h218, 32'h318, 0, "R4 eret both");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 7) op = 4'b0001 << $urandom_range(0, 3);
            else if (sel == 7) op = '0;
            else op = 4'($urandom);
            run_op(op, $urandom, $urandom, $urandom, $urandom, 1'($urandom),
                   "rand R2 R3 R4 R5 R6 R9 R11");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule